// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block collects thirty-two interrupt sources and presents them to a processor as two request lines, one critical and one non-critical. For each source, software chooses whether a level or a transition is detected and which polarity counts as active. It can enable or mask the source and steer it to either request line. Every source input first passes through a two-flop synchroniser. Detected events are then held in a status register until software clears them by writing ones.

Software reaches the controller through a small word-addressed register bus with separate read and write strobes and a 32-bit data path. It sees the raw status, a masked view (status AND enable), and the per-source configuration. A combinational pending-source output gives the number of the highest-numbered source that is both pending and enabled, so a handler can dispatch without scanning the masked view itself.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable, critical, trigger and status registers read zero, the polarity register reads 0xFFFFFFFF, and both request outputs and the pending-valid flag are low.
- R2: The registers sit at these word addresses: status 0x0, enable 0x2, critical 0x3, polarity 0x4, trigger 0x5, masked status 0x6. Any other address (including 0x1, 0x7 and 0x8) reads zero, and writes to it change nothing. Read data appears on the cycle after the read strobe and holds until the next read.
- R3: Source n occupies bit 31−n of every per-source register and of the source input vector, so source 0 is the most significant bit.
- R4: With trigger bit 0 (level), a status bit sets whenever the synchronised input is at its active level: high if the polarity bit is 1, low if it is 0. The bit stays set after the input goes inactive, until software clears it.
- R5: In level mode, writing 1 to a status bit has no effect while the input is still active, whether the source is enabled or not.
- R6: With trigger bit 1 (edge), a status bit sets on the selected transition of the synchronised input (rising if the polarity bit is 1, falling if 0). It stays set until cleared, whatever the enable bit holds, and a steady input does not set it again.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged, so writing 0xFFFFFFFF clears every event that is not being held by an active level.
- R8: The masked status register reads as status AND enable, and reads zero when no enabled source is pending.
- R9: The critical output is the OR of the masked-status bits whose critical bit is 1. The non-critical output is the OR of those whose critical bit is 0.
- R10: The 5-bit pending-source output gives the highest-numbered source with masked status set. Its valid flag is high exactly when some masked-status bit is set.
- R11: An input change reaches the status register on the third rising clock edge after it is applied. If a clear write to that status bit lands on the same edge as a new event, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_in | input | 32 | Asynchronous source inputs, source n on bit 31−n |
| irq_crit_o | output | 1 | Critical interrupt request |
| irq_noncrit_o | output | 1 | Non-critical interrupt request |
| pend_id_o | output | 5 | Highest-numbered pending enabled source |
| pend_valid_o | output | 1 | Qualifies pend_id_o |

## Verification
Two functions can act on one status bit at the same edge: a clear written by software and a new edge event coming out of the synchroniser. The bench counts the three synchroniser and detection edges exactly, places the status write on the very edge where the event lands, and expects the bit to stay set. A second run, with the write one edge later, must leave the bit clear. In level mode the same kind of collision happens every cycle the input is held, and there the bench expects the clear to be ignored.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt controller: source count, bus widths
// and the register word addresses. Assumes a fixed 32-bit data bus.
package irqc_pkg;
    localparam int NSRC   = 32;
    localparam int ADDR_W = 4;
    localparam int ID_W   = $clog2(NSRC);

    localparam logic [ADDR_W-1:0] ADDR_STAT  = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_EN    = 4'h2;
    localparam logic [ADDR_W-1:0] ADDR_CRIT  = 4'h3;
    localparam logic [ADDR_W-1:0] ADDR_POL   = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_TRIG  = 4'h5;
    localparam logic [ADDR_W-1:0] ADDR_MSTAT = 4'h6;
endpackage

// File: rtl/irqc_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous inputs.
// Assumes each bit is treated on its own; no multi-bit coherence is implied.
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Purpose: two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/irqc_detect.sv
// Per-source event detection and status latching. Level mode sets the status
// bit every cycle the input is active, so a clear cannot win while the level
// is held. Edge mode compares the synchronised input with its previous value.
// A set always takes priority over a clear on the same edge.
module irqc_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] trig_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] stat_q;
    logic [N-1:0] set_w;

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic lvl_act;
        logic edge_evt;

        // Purpose: active level compares input with polarity.
        assign lvl_act  = (sync_i[b] == pol_i[b]);
        // Purpose: transition toward the active level is an edge event.
        assign edge_evt = lvl_act && (prev_q[b] != sync_i[b]);
        // Purpose: pick the detection style selected by the trigger bit.
        assign set_w[b] = trig_i[b] ? edge_evt : lvl_act;
    end

    // Purpose: keep the previous input sample and update the sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= sync_i;
            stat_q <= set_w | (stat_q & ~clr_i);
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/irqc_regs.sv
// Register file and bus decode. Holds enable, critical, polarity and trigger,
// turns status writes into a clear vector, and registers read data on the
// cycle after the read strobe. Unmapped addresses read zero and ignore writes.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [N-1:0]  wdata_i,
    output logic [N-1:0]  rdata_o,
    input  logic [N-1:0]  stat_i,
    input  logic [N-1:0]  mstat_i,
    output logic [N-1:0]  en_o,
    output logic [N-1:0]  crit_o,
    output logic [N-1:0]  pol_o,
    output logic [N-1:0]  trig_o,
    output logic [N-1:0]  clr_o
);
    logic [N-1:0] en_q, crit_q, pol_q, trig_q;
    logic [N-1:0] rd_mux;
    logic [N-1:0] rdata_q;

    // Purpose: configuration registers written by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            crit_q <= '0;
            pol_q  <= '1;
            trig_q <= '0;
        end else if (wr_i) begin
            if (addr_i == ADDR_EN)   en_q   <= wdata_i;
            if (addr_i == ADDR_CRIT) crit_q <= wdata_i;
            if (addr_i == ADDR_POL)  pol_q  <= wdata_i;
            if (addr_i == ADDR_TRIG) trig_q <= wdata_i;
        end
    end

    // Purpose: a status write produces a write-one-to-clear vector.
    assign clr_o = (wr_i && addr_i == ADDR_STAT) ? wdata_i : '0;

    // Purpose: select the register named by the address for a read.
    always_comb begin
        case (addr_i)
            ADDR_STAT:  rd_mux = stat_i;
            ADDR_EN:    rd_mux = en_q;
            ADDR_CRIT:  rd_mux = crit_q;
            ADDR_POL:   rd_mux = pol_q;
            ADDR_TRIG:  rd_mux = trig_q;
            ADDR_MSTAT: rd_mux = mstat_i;
            default:    rd_mux = '0;
        endcase
    end

    // Purpose: capture read data on the strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;
    assign en_o    = en_q;
    assign crit_o  = crit_q;
    assign pol_o   = pol_q;
    assign trig_o  = trig_q;
endmodule

// File: rtl/irqc_out.sv
// Output stage: masking, routing to the critical and non-critical lines,
// and a priority pick of the highest-numbered pending source. Source n is
// bit N-1-n, so the highest-numbered source is the lowest set bit index.
module irqc_out #(
    parameter int N    = 32,
    parameter int ID_W = $clog2(N)
) (
    input  logic [N-1:0]    stat_i,
    input  logic [N-1:0]    en_i,
    input  logic [N-1:0]    crit_i,
    output logic [N-1:0]    mstat_o,
    output logic            crit_o,
    output logic            noncrit_o,
    output logic [ID_W-1:0] id_o,
    output logic            valid_o
);
    logic [N-1:0]    mstat;
    logic [ID_W-1:0] id_w;

    // Purpose: masked status is status gated by enable.
    assign mstat = stat_i & en_i;

    // Purpose: steer each pending source to one of the two request lines.
    assign crit_o    = |(mstat & crit_i);
    assign noncrit_o = |(mstat & ~crit_i);

    // Purpose: scan downward so the lowest set bit index wins last.
    always_comb begin
        id_w = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mstat[i]) id_w = ID_W'(N - 1 - i);
        end
    end

    assign id_o    = id_w;
    assign valid_o = |mstat;
    assign mstat_o = mstat;
endmodule

// File: rtl/irqc_top.sv
// Top of the 32-source interrupt controller. Chains synchroniser, detection,
// register file and output stage. Assumes irq_in is asynchronous and that
// the bus strobes are synchronous to clk.
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   irq_in,
    output logic              irq_crit_o,
    output logic              irq_noncrit_o,
    output logic [ID_W-1:0]   pend_id_o,
    output logic              pend_valid_o
);
    logic [NSRC-1:0] sync_s;
    logic [NSRC-1:0] stat_q;
    logic [NSRC-1:0] mstat;
    logic [NSRC-1:0] en_q, crit_q, pol_q, trig_q, clr_v;

    irqc_sync #(.W(NSRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .sync_o  (sync_s)
    );

    irqc_detect #(.N(NSRC)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_s),
        .pol_i  (pol_q),
        .trig_i (trig_q),
        .clr_i  (clr_v),
        .stat_o (stat_q)
    );

    irqc_regs #(.N(NSRC), .AW(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .stat_i  (stat_q),
        .mstat_i (mstat),
        .en_o    (en_q),
        .crit_o  (crit_q),
        .pol_o   (pol_q),
        .trig_o  (trig_q),
        .clr_o   (clr_v)
    );

    irqc_out #(.N(NSRC), .ID_W(ID_W)) u_out (
        .stat_i    (stat_q),
        .en_i      (en_q),
        .crit_i    (crit_q),
        .mstat_o   (mstat),
        .crit_o    (irq_crit_o),
        .noncrit_o (irq_noncrit_o),
        .id_o      (pend_id_o),
        .valid_o   (pend_valid_o)
    );
endmodule

// File: rtl/irqc_chk.sv
// Assertion checker bound into irqc_top. Observes ports and internal state.
module irqc_chk #(
    parameter int N    = 32,
    parameter int AW   = 4,
    parameter int ID_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [N-1:0]    bus_wdata,
    input logic [N-1:0]    bus_rdata,
    input logic [N-1:0]    sync_s,
    input logic [N-1:0]    stat_q,
    input logic [N-1:0]    en_q,
    input logic [N-1:0]    pol_q,
    input logic [N-1:0]    trig_q,
    input logic            irq_crit_o,
    input logic            irq_noncrit_o,
    input logic [ID_W-1:0] pend_id_o,
    input logic            pend_valid_o
);
    logic [N-1:0] clr_seen;
    logic [N-1:0] lvl_hold;

    assign clr_seen = (bus_wr && bus_addr == '0) ? bus_wdata : '0;
    assign lvl_hold = ~trig_q & ~(sync_s ^ pol_q);

    // R2: read data only changes after a read strobe
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));

    // R4, R5: an active level always leaves the status bit set
    assert_level_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & $past(lvl_hold)) == $past(lvl_hold)));

    // R7: status bits are sticky unless a clear was written
    assert_stat_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_q & ~clr_seen) & ~stat_q) == '0));

    // R9, R10: a request line is raised exactly when a source is pending
    assert_valid_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o == (irq_crit_o || irq_noncrit_o));

    // R10: the reported source is pending and enabled
    assert_id_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o |-> (stat_q[N-1-int'(pend_id_o)] && en_q[N-1-int'(pend_id_o)]));
endmodule

bind irqc_top irqc_chk #(.N(irqc_pkg::NSRC), .AW(irqc_pkg::ADDR_W), .ID_W(irqc_pkg::ID_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .sync_s        (sync_s),
    .stat_q        (stat_q),
    .en_q          (en_q),
    .pol_q         (pol_q),
    .trig_q        (trig_q),
    .irq_crit_o    (irq_crit_o),
    .irq_noncrit_o (irq_noncrit_o),
    .pend_id_o     (pend_id_o),
    .pend_valid_o  (pend_valid_o)
);

// File: tb/tb_irqc_top.sv
// Directed bench for irqc_top: one task per scenario, each checking itself.
module tb_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        irq_crit_o, irq_noncrit_o, pend_valid_o;
    logic [4:0]  pend_id_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_crit_o(irq_crit_o), .irq_noncrit_o(irq_noncrit_o),
        .pend_id_o(pend_id_o), .pend_valid_o(pend_valid_o)
    );

    function automatic logic [31:0] sb(input int n);
        return 32'h1 << (31 - n);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd_reg(4'h2, d); chk("R1 enable", d, 32'h0);
        rd_reg(4'h3, d); chk("R1 critical", d, 32'h0);
        rd_reg(4'h5, d); chk("R1 trigger", d, 32'h0);
        rd_reg(4'h4, d); chk("R1 polarity", d, 32'hFFFF_FFFF);
        rd_reg(4'h0, d); chk("R1 status", d, 32'h0);
        chk("R1 outputs", {29'b0, irq_crit_o, irq_noncrit_o, pend_valid_o}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr_reg(4'h2, 32'h1234_5678); rd_reg(4'h2, d); chk("R2 enable rw", d, 32'h1234_5678);
        wr_reg(4'h3, 32'hCAFE_0001); rd_reg(4'h3, d); chk("R2 critical rw", d, 32'hCAFE_0001);
        wr_reg(4'h1, 32'hFFFF_FFFF); rd_reg(4'h1, d); chk("R2 addr1 zero", d, 32'h0);
        wr_reg(4'h7, 32'hFFFF_FFFF); rd_reg(4'h7, d); chk("R2 addr7 zero", d, 32'h0);
        wr_reg(4'h8, 32'hFFFF_FFFF); rd_reg(4'h8, d); chk("R2 addr8 zero", d, 32'h0);
        rd_reg(4'h2, d); chk("R2 enable untouched", d, 32'h1234_5678);
        rd_reg(4'h5, d); chk("R2 trigger untouched", d, 32'h0);
        wr_reg(4'h2, 32'h0); wr_reg(4'h3, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        irq_in = sb(3); settle();
        rd_reg(4'h0, d); chk("R3 R4 level high source 3 at bit 28", d, 32'h1000_0000);
        rd_reg(4'h6, d); chk("R8 masked zero when disabled", d, 32'h0);
        wr_reg(4'h0, sb(3)); rd_reg(4'h0, d); chk("R5 clear ignored while active", d, sb(3));
        wr_reg(4'h2, sb(3)); wr_reg(4'h0, sb(3)); rd_reg(4'h0, d);
        chk("R5 clear ignored while enabled", d, sb(3));
        wr_reg(4'h2, 32'h0);
        irq_in = '0; settle();
        rd_reg(4'h0, d); chk("R4 level latched after release", d, sb(3));
        wr_reg(4'h0, 32'h0); rd_reg(4'h0, d); chk("R7 write zero keeps", d, sb(3));
        wr_reg(4'h0, sb(3)); rd_reg(4'h0, d); chk("R7 clear", d, 32'h0);
        // active-low on source 5 with input low
        wr_reg(4'h4, ~sb(5)); settle();
        rd_reg(4'h0, d); chk("R4 active-low sets", d, sb(5));
        irq_in = sb(5); settle();
        wr_reg(4'h0, 32'hFFFF_FFFF); rd_reg(4'h0, d); chk("R7 clear all", d, 32'h0);
        irq_in = '0; settle();
        wr_reg(4'h4, 32'hFFFF_FFFF); wr_reg(4'h0, 32'hFFFF_FFFF);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr_reg(4'h5, sb(10));
        irq_in = sb(10); settle();
        rd_reg(4'h0, d); chk("R6 rising sets while disabled", d, sb(10));
        wr_reg(4'h0, sb(10)); settle();
        rd_reg(4'h0, d); chk("R6 steady high no re-set", d, 32'h0);
        irq_in = '0; settle();
        rd_reg(4'h0, d); chk("R6 falling ignored in rising mode", d, 32'h0);
        wr_reg(4'h4, ~sb(10));
        irq_in = sb(10); settle();
        rd_reg(4'h0, d); chk("R6 rising ignored in falling mode", d, 32'h0);
        irq_in = '0; settle();
        rd_reg(4'h0, d); chk("R6 falling sets", d, sb(10));
        wr_reg(4'h0, 32'hFFFF_FFFF); rd_reg(4'h0, d); chk("R7 edge clear", d, 32'h0);
        wr_reg(4'h4, 32'hFFFF_FFFF); wr_reg(4'h5, 32'h0);
        wr_reg(4'h0, 32'hFFFF_FFFF);
    endtask

    task automatic t_route();
        logic [31:0] d;
        irq_in = sb(2) | sb(20); settle();
        wr_reg(4'h2, sb(2) | sb(20)); wr_reg(4'h3, sb(20));
        rd_reg(4'h6, d); chk("R8 masked view", d, sb(2) | sb(20));
        chk("R9 both lines", {30'b0, irq_crit_o, irq_noncrit_o}, 32'h3);
        chk("R10 highest source", {27'b0, pend_id_o}, 32'd20);
        wr_reg(4'h2, sb(2));
        chk("R9 crit drops", {30'b0, irq_crit_o, irq_noncrit_o}, 32'h1);
        chk("R10 next source", {26'b0, pend_valid_o, pend_id_o}, {26'b0, 1'b1, 5'd2});
        wr_reg(4'h3, sb(2) | sb(20));
        chk("R9 rerouted critical", {30'b0, irq_crit_o, irq_noncrit_o}, 32'h2);
        wr_reg(4'h2, 32'h0);
        rd_reg(4'h6, d); chk("R8 masked zero", d, 32'h0);
        chk("R10 valid low", {31'b0, pend_valid_o}, 32'h0);
        irq_in = '0; settle();
        wr_reg(4'h3, 32'h0); wr_reg(4'h0, 32'hFFFF_FFFF);
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr_reg(4'h5, sb(7)); wr_reg(4'h2, sb(7));
        @(negedge clk); irq_in = sb(7);
        @(posedge clk); @(negedge clk);
        chk("R11 not yet after edge 1", {31'b0, pend_valid_o}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R11 not yet after edge 2", {31'b0, pend_valid_o}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R11 set after edge 3", {26'b0, pend_valid_o, pend_id_o}, {26'b0, 1'b1, 5'd7});
        irq_in = '0; settle();
        wr_reg(4'h0, sb(7));
        // clear written on the event edge
        @(negedge clk); irq_in = sb(7);
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_addr = 4'h0; bus_wdata = sb(7); bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
        rd_reg(4'h0, d); chk("R11 event beats clear", d, sb(7));
        irq_in = '0; settle();
        wr_reg(4'h0, sb(7));
        // clear one edge after the event
        @(negedge clk); irq_in = sb(7);
        @(posedge clk); @(posedge clk); @(posedge clk);
        @(negedge clk); bus_addr = 4'h0; bus_wdata = sb(7); bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
        rd_reg(4'h0, d); chk("R11 later clear wins", d, 32'h0);
        irq_in = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_map();
        t_level();
        t_edge();
        t_route();
        t_race();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule